// File: doc/BRIEF.md
# Half-Group Memory Request Coalescer

This block receives one memory access request issued jointly by 32 parallel threads. It reduces that request to a short list of aligned memory transactions. It captures each thread's byte address, a mask of the threads taking part, and a code for the word size they all use. The 32 threads form two groups of 16, a lower group and an upper group. Each group is resolved on its own, and the lower group always goes first.

Each step starts from the lowest-numbered thread in the current group that is still waiting. The block finds the aligned segment holding that thread's word, and every other waiting thread of the group that falls in the same segment joins the transaction. The transaction is then narrowed to whichever half of the segment is actually touched, first from 128 to 64 bytes and then from 64 to 32 bytes. It is offered on a valid/ready port. When it is taken, its threads are retired. A one-cycle done pulse closes the request, and only then does the block accept the next one.

Top module: `coal_top`

## Requirements
- R1: After reset, `req_ready` is 1, and both `txn_valid` and `done` are 0.
- R2: Every transaction of the lower group (threads 0 to 15, `txn_half`=0) is issued before any transaction of the upper group (threads 16 to 31, `txn_half`=1). Bit j of `txn_mask` stands for thread `txn_half`*16+j.
- R3: The segment size comes from `req_wsize`. The codes are 0 for 1-byte words, 1 for 2-byte words, 2 for 4-byte words, 3 for 8-byte words and 4 for 16-byte words, and codes 5 to 7 act as 16-byte words. Code 0 gives 32-byte segments, code 1 gives 64-byte segments, and codes 2 and above give 128-byte segments. `txn_base` is always a multiple of `txn_bytes`.
- R4: Each transaction contains the lowest-numbered waiting thread of its group. It also contains every other waiting thread of that group whose word lies in the same segment, and no other thread.
- R5: `txn_bytes` is the byte count 128, 64 or 32. A 128-byte transaction whose threads all sit in one 64-byte half shrinks to that half. A 64-byte transaction, whether original or shrunk, whose threads all sit in one 32-byte half shrinks to that half. `txn_base` moves to the half that is kept.
- R6: Threads are retired when their transaction is taken (`txn_valid` and `txn_ready` both 1). Every active thread is served exactly once, and the block issues the exact sequence that R2 to R5 define.
- R7: A group of 16 consecutive 4-byte words starting at segment offset 80 produces exactly two transactions: 64 bytes at offset 64, then 32 bytes at the next segment's base.
- R8: When every thread of a group falls in its own segment, the group produces 16 transactions, each of 32 bytes.
- R9: While `txn_valid` is 1 and `txn_ready` is 0, the offered transaction stays valid and unchanged.
- R10: While a request is in progress, `req_ready` is 0, and a request offered on the input has no effect on the transaction stream.
- R11: A group with no active threads produces no transactions. With an empty mask, `done` is 1 in the cycle that follows the accept. `done` lasts one cycle, and `req_ready` returns to 1 in the next cycle.
- R12: Address bits below the word size are ignored, because each address is taken as aligned to its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken when both are 1 |
| req_addr | input | NTHR*ADDR_W | Byte address per thread; thread i in bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | NTHR | Thread takes part when its bit is 1 |
| req_wsize | input | 3 | Word size code (see R3) |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_base | output | ADDR_W | Transaction base byte address |
| txn_bytes | output | 8 | Transaction size in bytes: 32, 64 or 128 |
| txn_half | output | 1 | 0 for the lower thread group, 1 for the upper |
| txn_mask | output | NTHR/2 | Threads of the group served by this transaction |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench builds the block with its default of 32 threads and 32-bit addresses. At this size, one request covers both groups and every segment and shrink case. The bench sweeps all five word-size codes against strides of 1 to 33 words, a permuted order, eight start offsets and four mask shapes, among them an empty lower group and scattered bits. Back-pressure is applied every third cycle on alternate runs, which brings the hold and stability rules within reach across the whole sweep.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [2:0] {
    WS_1B  = 3'd0,
    WS_2B  = 3'd1,
    WS_4B  = 3'd2,
    WS_8B  = 3'd3,
    WS_16B = 3'd4
  } wsize_e;

  // Aligned segment size in bytes for a word-size code.
  function automatic logic [7:0] seg_bytes(input logic [2:0] ws);
    case (ws)
      WS_1B:   return 8'd32;
      WS_2B:   return 8'd64;
      default: return 8'd128;
    endcase
  endfunction

  // Word size in bytes for a word-size code.
  function automatic logic [4:0] word_bytes(input logic [2:0] ws);
    case (ws)
      WS_1B:   return 5'd1;
      WS_2B:   return 5'd2;
      WS_4B:   return 5'd4;
      WS_8B:   return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/coal_lead.sv
module coal_lead #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  // Lowest set bit wins.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/coal_group.sv
module coal_group
  import coal_pkg::*;
#(
  parameter int HALF   = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(HALF)
) (
  input  logic [HALF*ADDR_W-1:0] addr,
  input  logic [HALF-1:0]        pend,
  input  logic [2:0]             ws,
  input  logic [IDX_W-1:0]       lead_idx,
  output logic [ADDR_W-1:0]      base,
  output logic [7:0]             bytes,
  output logic [HALF-1:0]        mask
);

  logic [ADDR_W-1:0] seg_len, seg_msk, word_msk, seg_base;
  logic [ADDR_W-1:0] a_al [HALF];
  logic              u6lo, u6hi, u5lo, u5hi;

  assign seg_len  = ADDR_W'(seg_bytes(ws));
  assign seg_msk  = ~(seg_len - ADDR_W'(1));
  assign word_msk = ~(ADDR_W'(word_bytes(ws)) - ADDR_W'(1));

  // Per-thread aligned address and segment match.
  for (genvar gi = 0; gi < HALF; gi++) begin : g_thr
    assign a_al[gi] = addr[gi*ADDR_W +: ADDR_W] & word_msk;
    assign mask[gi] = pend[gi] && ((a_al[gi] & seg_msk) == seg_base);
  end

  assign seg_base = a_al[lead_idx] & seg_msk;

  // Which halves of the 128B and 64B windows are touched.
  always_comb begin
    u6lo = 1'b0;
    u6hi = 1'b0;
    u5lo = 1'b0;
    u5hi = 1'b0;
    for (int i = 0; i < HALF; i++) begin
      if (mask[i]) begin
        if (a_al[i][6]) u6hi = 1'b1;
        else            u6lo = 1'b1;
        if (a_al[i][5]) u5hi = 1'b1;
        else            u5lo = 1'b1;
      end
    end
  end

  // Two-step shrink: 128 -> 64, then 64 -> 32.
  always_comb begin
    bytes = seg_bytes(ws);
    base  = seg_base;
    if (bytes == 8'd128 && !(u6lo && u6hi)) begin
      bytes   = 8'd64;
      base[6] = u6hi;
    end
    if (bytes == 8'd64 && !(u5lo && u5hi)) begin
      bytes   = 8'd32;
      base[5] = u5hi;
    end
  end

endmodule

// File: rtl/coal_top.sv
module coal_top
  import coal_pkg::*;
#(
  parameter int NTHR   = 32,
  parameter int ADDR_W = 32,
  localparam int HALF  = NTHR / 2,
  localparam int IDX_W = $clog2(HALF)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [NTHR*ADDR_W-1:0] req_addr,
  input  logic [NTHR-1:0]        req_mask,
  input  logic [2:0]             req_wsize,
  output logic                   txn_valid,
  input  logic                   txn_ready,
  output logic [ADDR_W-1:0]      txn_base,
  output logic [7:0]             txn_bytes,
  output logic                   txn_half,
  output logic [HALF-1:0]        txn_mask,
  output logic                   done
);

  logic                   busy_q, busy_d;
  logic [NTHR-1:0]        pend_q, pend_d;
  logic [NTHR*ADDR_W-1:0] addr_q;
  logic [2:0]             ws_q;
  logic                   load_en, fire, sel_hi, any_pend;
  logic [HALF-1:0]        pend_lo, pend_hi, pend_cur;
  logic [HALF*ADDR_W-1:0] addr_cur;
  logic [IDX_W-1:0]       lead_idx;

  assign pend_lo  = pend_q[0 +: HALF];
  assign pend_hi  = pend_q[HALF +: HALF];
  assign sel_hi   = ~|pend_lo;
  assign pend_cur = sel_hi ? pend_hi : pend_lo;
  assign addr_cur = sel_hi ? addr_q[HALF*ADDR_W +: HALF*ADDR_W]
                           : addr_q[0 +: HALF*ADDR_W];

  coal_lead #(.N(HALF)) u_lead (
    .vec (pend_cur),
    .idx (lead_idx),
    .any (any_pend)
  );

  coal_group #(.HALF(HALF), .ADDR_W(ADDR_W)) u_group (
    .addr     (addr_cur),
    .pend     (pend_cur),
    .ws       (ws_q),
    .lead_idx (lead_idx),
    .base     (txn_base),
    .bytes    (txn_bytes),
    .mask     (txn_mask)
  );

  assign req_ready = ~busy_q;
  assign txn_valid = busy_q & any_pend;
  assign txn_half  = sel_hi;
  assign done      = busy_q & ~|pend_q;
  assign load_en   = req_valid & req_ready;
  assign fire      = txn_valid & txn_ready;

  // Next state
  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    if (load_en) begin
      busy_d = 1'b1;
      pend_d = req_mask;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (fire) begin
      if (sel_hi) pend_d[HALF +: HALF] = pend_hi & ~txn_mask;
      else        pend_d[0 +: HALF]    = pend_lo & ~txn_mask;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
    end
  end

  // Request payload, loaded only on accept
  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= req_addr;
      ws_q   <= req_wsize;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_bytes)
      && $stable(txn_mask) && $stable(txn_half)); // R9
  AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_base & (ADDR_W'(txn_bytes) - ADDR_W'(1))) == '0); // R3
  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_mask[lead_idx] && ((txn_mask & ~pend_cur) == '0)); // R4
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_bytes == 8'd32 || txn_bytes == 8'd64 || txn_bytes == 8'd128)
      && txn_bytes <= seg_bytes(ws_q)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R11
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready); // R10
  AST_HALF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_half |=> !(txn_valid && !txn_half)); // R2

endmodule

// File: tb/coal_top_tb_top.sv
`timescale 1ns/1ps
module coal_top_tb_top;

  localparam int NTHR = 32;
  localparam int AW   = 32;
  localparam int HALF = NTHR / 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready;
  logic [NTHR*AW-1:0] req_addr;
  logic [NTHR-1:0]   req_mask;
  logic [2:0]        req_wsize;
  logic              txn_valid, txn_ready;
  logic [AW-1:0]     txn_base;
  logic [7:0]        txn_bytes;
  logic              txn_half;
  logic [HALF-1:0]   txn_mask;
  logic              done;

  always #10 clk = ~clk;

  coal_top #(.NTHR(NTHR), .ADDR_W(AW)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_mask, .req_wsize,
    .txn_valid, .txn_ready, .txn_base, .txn_bytes, .txn_half, .txn_mask, .done
  );

  int n_chk = 0;
  int n_err = 0;

  logic [AW-1:0]   ta [NTHR];
  logic [NTHR-1:0] tmask;
  logic [AW-1:0]   e_base [64];
  int              e_bytes [64];
  logic            e_half [64];
  logic [HALF-1:0] e_mask [64];
  int              e_n;
  logic [AW-1:0]   g_base [64];
  int              g_bytes [64];
  int              g_n, done_cyc, stall_ctr;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int wbytes(input int ws);
    return (ws >= 4) ? 16 : (1 << ws);
  endfunction

  // Reference model built from the requirements (R2..R6, R12).
  task automatic model(input int ws);
    int wb, seg, lead, mn, mx, sz, off;
    logic [HALF-1:0] pend, m;
    logic [AW-1:0] sb, al;
    wb  = wbytes(ws);
    seg = (ws == 0) ? 32 : (ws == 1) ? 64 : 128;
    e_n = 0;
    for (int h = 0; h < 2; h++) begin
      pend = tmask[h*HALF +: HALF];
      while (pend != 0) begin
        lead = 0;
        while (!pend[lead]) lead++;
        al = ta[h*HALF+lead] / wb * wb;
        sb = al / seg * seg;
        m = '0; mn = seg; mx = 0;
        for (int j = 0; j < HALF; j++) begin
          al = ta[h*HALF+j] / wb * wb;
          if (pend[j] && (al / seg * seg) == sb) begin
            m[j] = 1'b1;
            off = int'(al - sb);
            if (off < mn) mn = off;
            if (off + wb - 1 > mx) mx = off + wb - 1;
          end
        end
        sz = seg;
        while (sz > 32 && (mn / (sz/2)) == (mx / (sz/2))) sz = sz / 2;
        e_base[e_n]  = sb + AW'(mn / sz * sz);
        e_bytes[e_n] = sz;
        e_half[e_n]  = h[0];
        e_mask[e_n]  = m;
        e_n++;
        pend = pend & ~m;
      end
    end
  endtask

  task automatic pack();
    for (int i = 0; i < NTHR; i++) req_addr[i*AW +: AW] = ta[i];
    req_mask = tmask;
  endtask

  // Issue one request, collect and compare its stream. Called at a negedge.
  task automatic run_req(input int ws, input bit stall, input bit poke, input string tag);
    int cyc;
    bit seen;
    logic [63:0] act, exp, held;
    bit have_held;
    model(ws);
    pack();
    req_wsize = 3'(ws);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    g_n = 0; cyc = 0; seen = 1'b0; done_cyc = -1; have_held = 1'b0;
    while (!seen && cyc < 400) begin
      req_valid = 1'b0;
      if (have_held) begin
        act = {txn_valid, txn_half, 7'(0), txn_bytes, txn_mask, txn_base};
        chk(act == held, {"R9 hold under stall ", tag}, act, held);
        have_held = 1'b0;
      end
      if (done) begin
        seen = 1'b1;
        done_cyc = cyc;
        chk(g_n == e_n, {"R6 transaction count ", tag}, 64'(g_n), 64'(e_n));
      end else begin
        if (poke && cyc < 3) begin
          chk(req_ready == 1'b0, {"R10 ready low while busy ", tag}, 64'(req_ready), 64'd0);
          req_valid = 1'b1;
          for (int i = 0; i < NTHR; i++) req_addr[i*AW +: AW] = 32'h7000_0000 + AW'(i*4096);
          req_mask = '1;
          req_wsize = 3'd0;
        end
        stall_ctr++;
        txn_ready = !(stall && (stall_ctr % 3 == 0));
        if (txn_valid && !txn_ready) begin
          held = {txn_valid, txn_half, 7'(0), txn_bytes, txn_mask, txn_base};
          have_held = 1'b1;
        end
        if (txn_valid && txn_ready) begin
          act = {txn_half, 7'(0), txn_bytes, txn_mask, txn_base};
          if (g_n < e_n)
            exp = {e_half[g_n], 7'(0), 8'(e_bytes[g_n]), e_mask[g_n], e_base[g_n]};
          else
            exp = '1;
          chk(act == exp, {"R2 R4 R5 transaction ", tag}, act, exp);
          if (g_n < 64) begin
            g_base[g_n]  = txn_base;
            g_bytes[g_n] = int'(txn_bytes);
          end
          g_n++;
        end
      end
      cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    txn_ready = 1'b0;
    chk(seen, {"R11 done seen ", tag}, 64'(seen), 64'd1);
    chk(!done && req_ready, {"R11 done single pulse ", tag}, {62'd0, done, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int strides [8];
    int offs [8];
    logic [31:0] masks [4];
    strides = '{1, 2, 3, 4, 8, 16, 33, 0};
    offs    = '{0, 1, 3, 7, 12, 20, 31, 45};
    masks   = '{32'hFFFF_FFFF, 32'hA5A5_3C3C, 32'hFFFF_0000, 32'h8001_0240};
    stall_ctr = 0;
    rst_n = 1'b0; req_valid = 1'b0; txn_ready = 1'b0;
    req_addr = '0; req_mask = '0; req_wsize = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready && !txn_valid && !done, "R1 reset state", {61'd0, req_ready, txn_valid, done}, 64'h4);

    // R7: misaligned 4-byte run crossing a 128-byte boundary in each group
    for (int i = 0; i < NTHR; i++) ta[i] = 32'h0000_2000 + AW'((i / HALF) * 32'h1000) + AW'(80 + 4 * (i % HALF));
    tmask = '1;
    run_req(2, 1'b0, 1'b0, "misaligned");
    chk(g_n == 4, "R7 two transactions per group", 64'(g_n), 64'd4);
    chk(g_bytes[0] == 64 && g_base[0] == 32'h2040, "R7 first 64B", {24'(g_bytes[0]), g_base[0]}, {24'd64, 32'h2040});
    chk(g_bytes[1] == 32 && g_base[1] == 32'h2080, "R7 second 32B", {24'(g_bytes[1]), g_base[1]}, {24'd32, 32'h2080});

    // R8: one segment per thread
    for (int i = 0; i < NTHR; i++) ta[i] = AW'(i * 128);
    run_req(2, 1'b1, 1'b0, "stride128");
    chk(g_n == 32, "R8 sixteen per group", 64'(g_n), 64'd32);
    chk(g_bytes[5] == 32, "R8 each 32B", 64'(g_bytes[5]), 64'd32);

    // R11: empty request
    tmask = '0;
    run_req(2, 1'b0, 1'b0, "empty");
    chk(done_cyc == 0, "R11 done right after accept", 64'(done_cyc), 64'd0);

    // R12: low address bits ignored for 8-byte words
    for (int i = 0; i < NTHR; i++) ta[i] = AW'(i * 8 + 3);
    tmask = '1;
    run_req(3, 1'b0, 1'b0, "lowbits");
    chk(g_n == 2 && g_bytes[0] == 128, "R12 one 128B per group", {32'(g_n), 32'(g_bytes[0])}, {32'd2, 32'd128});

    // R10: requests offered while busy are refused and ignored
    for (int i = 0; i < NTHR; i++) ta[i] = 32'h0100_0000 + AW'(i * 36);
    run_req(1, 1'b1, 1'b1, "poke");

    // R3 R5 R6 sweep across word sizes, strides, offsets and masks
    for (int ws = 0; ws < 5; ws++)
      for (int s = 0; s < 8; s++)
        for (int o = 0; o < 8; o++)
          for (int mk = 0; mk < 4; mk++) begin
            int wb;
            wb = wbytes(ws);
            for (int i = 0; i < NTHR; i++) begin
              if (strides[s] == 0)
                ta[i] = 32'h4000_0000 + AW'(ws * 32'h10000) + AW'((offs[o] + ((i * 7) % NTHR)) * wb);
              else
                ta[i] = 32'h4000_0000 + AW'(ws * 32'h10000) + AW'((offs[o] + i * strides[s]) * wb);
            end
            tmask = masks[mk];
            run_req(ws, ((ws + mk) % 2) == 1, 1'b0, "sweep R3");
          end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule